// File: doc/BRIEF.md
# Guest State Consistency Checker

This block judges whether a candidate set of guest control, debug and mode register values, together with a handful of control-block fields, may be entered as a guest. It evaluates a fixed list of illegal-combination rules in one combinational pass. On a check strobe it registers a per-rule violation mask and a single legal flag. A caller drives the candidate values, pulses `chk_valid`, and one cycle later reads `legal`. When that flag is low, the mask tells it exactly which rules failed.

Two conditions are delegated to upstream logic and arrive as single-bit flags: illegal reserved bits in the page-table base register, and an illegal pending event injection. A separate combinational path sign-extends a segment base address from the implemented virtual-address width, so that it comes out in canonical form.

A CR0 value with protection disabled but paging enabled is deliberately tolerated when it appears alone. It only becomes illegal through the long-mode rules, which require both the long-mode enable bit and the paging bit.

Top module: `guest_state_checker`

## Requirements
- R1: When EFER bit 12 (virtualization enable) is 0, mask bit 0 is set.
- R2: When CR0 bit 30 (cache disable) is 0 and CR0 bit 29 (not write-through) is 1, mask bit 1 is set.
- R3: Nonzero reserved upper bits set their own mask bits: CR0[63:32] sets bit 2, CR4[63:11] sets bit 4, DR6[63:32] sets bit 5, DR7[63:32] sets bit 6 and EFER[63:15] sets bit 7. Any value of CR3 has no effect on the mask.
- R4: The CR3-reserved flag sets mask bit 3, and the illegal-event flag sets mask bit 14.
- R5: When EFER bit 8 (long-mode enable) or bit 10 (long-mode active) is set and `lm_ok` is 0, mask bit 8 is set.
- R6: When EFER bit 8 and CR0 bit 31 (paging) are both set, mask bit 9 is set if CR4 bit 5 (PAE) is 0, and mask bit 10 is set if CR0 bit 0 (protection enable) is 0.
- R7: When EFER bit 8, CR0 bit 31, CR4 bit 5, `cs_l` and `cs_d` are all set, mask bit 11 is set.
- R8: A clear `run_icpt` sets mask bit 12, and `asid` equal to zero sets mask bit 15.
- R9: Mask bit 13 is set when `pa_width` is below 64 and `tbl_end` is at least 2^`pa_width`. It is never set when `pa_width` is 64 or more.
- R10: CR0 with bit 0 clear and bit 31 set, while EFER bit 8 is clear, sets no mask bit.
- R11: On a clock edge with `chk_valid` high, `viol` takes the rule mask, `legal` takes the NOR of the mask, and `result_valid` goes high for one cycle. While `chk_valid` is low, `viol` and `legal` hold their values.
- R12: After reset, `viol` is 0, `legal` is 0 and `result_valid` is 0.
- R13: `seg_base_out` equals `seg_base_in` with bits 63 down to VA_W copied from bit VA_W-1. The default VA_W is 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Capture strobe for the check result |
| cr0 | input | 64 | Candidate CR0 |
| cr3 | input | 64 | Candidate CR3 (reserved bits judged upstream) |
| cr4 | input | 64 | Candidate CR4 |
| dr6 | input | 64 | Candidate DR6 |
| dr7 | input | 64 | Candidate DR7 |
| efer | input | 64 | Candidate EFER |
| cs_l | input | 1 | Code segment long attribute |
| cs_d | input | 1 | Code segment default-size attribute |
| run_icpt | input | 1 | Intercept bit for the guest-entry instruction |
| asid | input | ASID_W | Address-space identifier |
| tbl_end | input | 64 | Highest address reached by the intercept tables |
| pa_width | input | 7 | Maximum supported physical address width |
| lm_ok | input | 1 | Long mode supported strap |
| cr3_rsvd | input | 1 | Reserved CR3 bits are set |
| evt_bad | input | 1 | Pending event injection is illegal |
| seg_base_in | input | 64 | Raw segment base |
| seg_base_out | output | 64 | Canonical segment base |
| viol | output | 16 | Registered per-rule violation mask |
| legal | output | 1 | Registered legal flag |
| result_valid | output | 1 | High for the cycle after a check |

## Verification
The bench sweeps all 256 combinations of the long-mode enable and active bits, paging, protection, PAE, the code-segment L and D bits and the long-mode strap. A design that tied the protection rule to CR0 alone would reject the tolerated PE=0/PG=1 state, and one that mixed up the PAE and L+D rules would fail some of those combinations. A single-bit walk across every register catches off-by-one reserved-field boundaries, such as CR4 bit 10 against bit 11, or EFER bit 14 against bit 15. It also catches a CR3 bit leaking into the mask. The intercept-table bound is checked at 2^w-1 and at 2^w for every width, which exposes a strict-versus-inclusive comparison error. A sweep of single set bits through the segment base exposes a sign extension taken from the wrong bit.

// File: rtl/guest_state_checker.sv
module guest_state_checker #(
  parameter int VA_W   = 48,
  parameter int ASID_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [63:0]       cr0,
  input  logic [63:0]       cr3,
  input  logic [63:0]       cr4,
  input  logic [63:0]       dr6,
  input  logic [63:0]       dr7,
  input  logic [63:0]       efer,
  input  logic              cs_l,
  input  logic              cs_d,
  input  logic              run_icpt,
  input  logic [ASID_W-1:0] asid,
  input  logic [63:0]       tbl_end,
  input  logic [6:0]        pa_width,
  input  logic              lm_ok,
  input  logic              cr3_rsvd,
  input  logic              evt_bad,
  input  logic [63:0]       seg_base_in,
  output logic [63:0]       seg_base_out,
  output logic [15:0]       viol,
  output logic              legal,
  output logic              result_valid
);
  localparam int EXT = 64 - VA_W;

  logic pe, nw, cd, pg, pae, lme, lma, svm_en, lm_pg, tbl_over;
  logic [15:0] rule;
  logic [63:0] cr3_unused;

  assign pe     = cr0[0];
  assign nw     = cr0[29];
  assign cd     = cr0[30];
  assign pg     = cr0[31];
  assign pae    = cr4[5];
  assign lme    = efer[8];
  assign lma    = efer[10];
  assign svm_en = efer[12];
  assign lm_pg  = lme & pg;
  assign cr3_unused = cr3;

  assign tbl_over = (pa_width >= 7'd64) ? 1'b0 : ((tbl_end >> pa_width) != 64'd0);

  assign rule[0]  = ~svm_en;
  assign rule[1]  = ~cd & nw;
  assign rule[2]  = |cr0[63:32];
  assign rule[3]  = cr3_rsvd;
  assign rule[4]  = |cr4[63:11];
  assign rule[5]  = |dr6[63:32];
  assign rule[6]  = |dr7[63:32];
  assign rule[7]  = |efer[63:15];
  assign rule[8]  = (lme | lma) & ~lm_ok;
  assign rule[9]  = lm_pg & ~pae;
  assign rule[10] = lm_pg & ~pe;
  assign rule[11] = lm_pg & pae & cs_l & cs_d;
  assign rule[12] = ~run_icpt;
  assign rule[13] = tbl_over;
  assign rule[14] = evt_bad;
  assign rule[15] = (asid == '0);

  assign seg_base_out = {{EXT{seg_base_in[VA_W-1]}}, seg_base_in[VA_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol         <= '0;
      legal        <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= chk_valid;
      if (chk_valid) begin
        viol  <= rule;
        legal <= ~|rule;
      end
    end
  end
endmodule

// File: rtl/guest_state_checker_sva.sv
module guest_state_checker_sva #(
  parameter int VA_W   = 48,
  parameter int ASID_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic [63:0]       cr0,
  input logic [63:0]       efer,
  input logic              run_icpt,
  input logic [ASID_W-1:0] asid,
  input logic [63:0]       seg_base_in,
  input logic [63:0]       seg_base_out,
  input logic [15:0]       viol,
  input logic              legal,
  input logic              result_valid
);
  assert_svm_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !efer[12] |=> viol[0] && !legal);

  assert_cd_nw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !cr0[30] && cr0[29] |=> viol[1] && !legal);

  assert_icpt_asid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && (!run_icpt || asid == '0) |=> !legal);

  assert_pe_pg_tolerated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !efer[8] |=> !viol[10] && !viol[9]);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> $stable(viol) && $stable(legal) && !result_valid);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> result_valid && (legal == (viol == 16'd0)));

  assert_canon_R13: assert property (@(posedge clk) disable iff (!rst_n)
    seg_base_out[VA_W-1:0] == seg_base_in[VA_W-1:0] &&
    (&seg_base_out[63:VA_W-1] || !(|seg_base_out[63:VA_W-1])));
endmodule

bind guest_state_checker guest_state_checker_sva #(.VA_W(VA_W), .ASID_W(ASID_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .cr0(cr0), .efer(efer),
  .run_icpt(run_icpt), .asid(asid), .seg_base_in(seg_base_in),
  .seg_base_out(seg_base_out), .viol(viol), .legal(legal),
  .result_valid(result_valid)
);

// File: tb/guest_state_checker_test.sv
`timescale 1ns/1ps
module guest_state_checker_test;
  logic clk = 1'b0, rst_n = 1'b0, chk_valid = 1'b0;
  logic [63:0] cr0, cr3, cr4, dr6, dr7, efer, tbl_end, seg_in;
  logic cs_l, cs_d, run_icpt, lm_ok, cr3_rsvd, evt_bad;
  logic [15:0] asid;
  logic [6:0] pa_width;
  logic [63:0] seg_out;
  logic [15:0] viol;
  logic legal, result_valid;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  guest_state_checker uut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .cr0(cr0), .cr3(cr3),
    .cr4(cr4), .dr6(dr6), .dr7(dr7), .efer(efer), .cs_l(cs_l), .cs_d(cs_d),
    .run_icpt(run_icpt), .asid(asid), .tbl_end(tbl_end), .pa_width(pa_width),
    .lm_ok(lm_ok), .cr3_rsvd(cr3_rsvd), .evt_bad(evt_bad),
    .seg_base_in(seg_in), .seg_base_out(seg_out), .viol(viol),
    .legal(legal), .result_valid(result_valid));

  function automatic logic [15:0] model();
    logic [15:0] m = '0;
    logic lme = efer[8];
    logic both = lme && cr0[31];
    if (efer[12] == 1'b0) m[0] = 1;
    if (cr0[30] == 1'b0 && cr0[29] == 1'b1) m[1] = 1;
    if ((cr0 >> 32) != 0) m[2] = 1;
    if (cr3_rsvd) m[3] = 1;
    if ((cr4 >> 11) != 0) m[4] = 1;
    if ((dr6 >> 32) != 0) m[5] = 1;
    if ((dr7 >> 32) != 0) m[6] = 1;
    if ((efer >> 15) != 0) m[7] = 1;
    if ((efer[8] || efer[10]) && !lm_ok) m[8] = 1;
    if (both && !cr4[5]) m[9] = 1;
    if (both && !cr0[0]) m[10] = 1;
    if (both && cr4[5] && cs_l && cs_d) m[11] = 1;
    if (!run_icpt) m[12] = 1;
    if (pa_width < 64 && tbl_end >= (64'd1 << pa_width)) m[13] = 1;
    if (evt_bad) m[14] = 1;
    if (asid == 0) m[15] = 1;
    return m;
  endfunction

  task automatic set_base();
    cr0 = 64'h1; cr3 = 64'h0; cr4 = 64'h0; dr6 = 64'h0; dr7 = 64'h0;
    efer = 64'h1000; cs_l = 0; cs_d = 0; run_icpt = 1; asid = 16'h1;
    tbl_end = 64'h1000; pa_width = 7'd40; lm_ok = 1; cr3_rsvd = 0; evt_bad = 0;
  endtask

  task automatic run_check(input string tag);
    logic [15:0] exp_m = model();
    chk_valid = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    tests++;
    if (viol !== exp_m || legal !== (exp_m == 16'd0) || result_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: viol=%h legal=%b rv=%b expected viol=%h legal=%b rv=1",
               tag, viol, legal, result_valid, exp_m, exp_m == 16'd0);
    end
  endtask

  task automatic check_seg(input logic [63:0] v, input logic [63:0] exp_v);
    seg_in = v;
    #1;
    tests++;
    if (seg_out !== exp_v) begin
      fails++;
      $display("FAIL R13: seg_out=%h expected %h (in %h)", seg_out, exp_v, v);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    set_base();
    seg_in = 64'h0;
    repeat (2) @(negedge clk);
    tests++;
    if (viol !== 16'd0 || legal !== 1'b0 || result_valid !== 1'b0) begin
      fails++;
      $display("FAIL R12: viol=%h legal=%b rv=%b expected 0 0 0", viol, legal, result_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    run_check("R11 base legal");
    efer = 64'h0; run_check("R1");
    set_base(); cr0 = 64'h2000_0001; run_check("R2");
    cr0 = 64'h6000_0001; run_check("R2 both set");
    set_base(); cr3_rsvd = 1; run_check("R4 cr3");
    set_base(); evt_bad = 1; run_check("R4 event");
    set_base(); run_icpt = 0; run_check("R8 intercept");
    set_base(); asid = 0; run_check("R8 asid");
    set_base(); cr0 = 64'h8000_0000; run_check("R10 pe0 pg1");

    // hold: change inputs with strobe low, results must not move
    set_base(); run_check("R11 pre-hold");
    efer = 64'h0; asid = 0;
    @(negedge clk); @(negedge clk);
    tests++;
    if (viol !== 16'd0 || legal !== 1'b1 || result_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 hold: viol=%h legal=%b rv=%b expected 0 1 0", viol, legal, result_valid);
    end

    for (int i = 0; i < 256; i++) begin
      set_base();
      efer[8] = i[0]; efer[10] = i[1]; cr0[31] = i[2]; cr0[0] = i[3];
      cr4[5] = i[4]; cs_l = i[5]; cs_d = i[6]; lm_ok = i[7];
      run_check("R5 R6 R7 R10 sweep");
    end

    for (int r = 0; r < 6; r++) begin
      for (int b = 0; b < 64; b++) begin
        set_base();
        case (r)
          0: cr0  = cr0  ^ (64'd1 << b);
          1: cr3  = cr3  ^ (64'd1 << b);
          2: cr4  = cr4  ^ (64'd1 << b);
          3: dr6  = dr6  ^ (64'd1 << b);
          4: dr7  = dr7  ^ (64'd1 << b);
          default: efer = efer ^ (64'd1 << b);
        endcase
        run_check("R3 bit walk");
      end
    end

    for (int w = 1; w < 64; w++) begin
      set_base(); pa_width = 7'(w);
      tbl_end = (64'd1 << w) - 64'd1; run_check("R9 below");
      tbl_end = 64'd1 << w;           run_check("R9 at limit");
    end
    set_base(); tbl_end = '1; pa_width = 7'd64; run_check("R9 width 64");
    pa_width = 7'd127; run_check("R9 width 127");

    for (int b = 0; b < 64; b++) begin
      if (b < 47)       check_seg(64'd1 << b, 64'd1 << b);
      else if (b == 47) check_seg(64'd1 << b, ~((64'd1 << 47) - 64'd1));
      else              check_seg(64'd1 << b, 64'd0);
    end
    check_seg(64'h1234_7FFF_FFFF_FFFF, 64'h0000_7FFF_FFFF_FFFF);
    check_seg(64'h0000_8000_0000_1000, 64'hFFFF_8000_0000_1000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule